// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each received Ethernet frame, whether the frame is kept. The receive path presents the 48-bit destination address from the frame header together with a one-cycle valid strobe. The filter classes the address as unicast, multicast or broadcast. A unicast address is compared against the one station address. A multicast address is looked up in a 64-bin hash table, indexed by part of a CRC-32 of the address. A broadcast address passes unless broadcast reception is turned off.

Five mode inputs modify the normal outcome. Promiscuous accepts everything. Pass-all-multicast accepts any group address. Inverse flips the sense of the perfect unicast match. Broadcast-disable drops the all-ones address. Pass-all-with-status accepts every frame but still reports the outcome of the normal filter. The configuration is taken from plain input ports. The result is a registered accept flag plus a small status word that gives the address class, the rule that decided, and the normal filter outcome.

Top module: `rx_addr_filter`

## Requirements
- R1: While `rst` is high, and after it until the first strobe, `accept`, `filter_pass`, `addr_class` and `match_rule` are all zero.
- R2: All outputs take the decision for the address presented with `addr_valid` high at the first rising clock edge that samples the strobe. They keep that value, whatever the inputs do, until the next strobe.
- R3: `dest_addr[7:0]` is the first byte on the wire, and `dest_addr[0]` is the group bit. `addr_class` is 0 for unicast (group bit clear), 2 for the all-ones broadcast address, and 1 for every other address with the group bit set.
- R4: With no mode set, a unicast address is accepted exactly when it equals `station_addr`, with `match_rule` 1. Otherwise it is rejected with `match_rule` 0.
- R5: The hash index is bits 31:26 of a CRC register. The register is preset to all ones and fed with `dest_addr[0]` first through `dest_addr[47]` last. It uses the reflected polynomial 0xEDB88320 and shifts right, with no final inversion. A multicast address whose bin `hash_table[index]` is set is accepted with `match_rule` 3.
- R6: With `pass_all_mcast` set, a multicast address that misses the hash table is still accepted, with `match_rule` 4.
- R7: With `inverse_match` set, a unicast address is accepted with `match_rule` 2 exactly when it differs from `station_addr`. Multicast and broadcast handling is unchanged.
- R8: A broadcast address is accepted with `match_rule` 5 unless `bcast_disable` is set, in which case the normal filter rejects it.
- R9: With `promisc` set, every address is accepted with `match_rule` 6. This includes broadcast while `bcast_disable` is set.
- R10: With `pass_all_status` set, every address is accepted. `filter_pass` still gives the normal filter outcome. `match_rule` is the normal rule when the filter passes, and 7 when it does not.
- R11: The rule priority is promiscuous, then the normal filter, then pass-all-with-status. `accept` is 1 exactly when `match_rule` is non-zero, and `filter_pass` high implies `accept` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | One-cycle strobe qualifying `dest_addr` |
| dest_addr | input | 48 | Destination address, first byte in bits 7:0 |
| station_addr | input | 48 | Station address for the perfect match |
| hash_table | input | 64 | Multicast hash bins, bit n is bin n |
| promisc | input | 1 | Accept every frame |
| pass_all_mcast | input | 1 | Accept every group address |
| inverse_match | input | 1 | Invert the perfect unicast match |
| bcast_disable | input | 1 | Reject the all-ones address in the normal filter |
| pass_all_status | input | 1 | Accept every frame, report the normal outcome |
| accept | output | 1 | Frame is kept |
| filter_pass | output | 1 | Normal filter outcome, ignoring promiscuous and pass-all |
| addr_class | output | 2 | 0 unicast, 1 multicast, 2 broadcast |
| match_rule | output | 3 | 0 none, 1 perfect, 2 inverse, 3 hash, 4 all-multicast, 5 broadcast, 6 promiscuous, 7 pass-all |

## Verification
The decision state is one register stage deep, so a wrong decision shows on the ports one clock after the strobe that caused it. A register that fails to hold shows up at the first idle cycle in which the address inputs change. A wrong CRC bit order or index slice moves multicast addresses into the wrong bin. That is caught by addresses whose own bin is the only bin set, and also when every bin except their own is set. A wrong priority between the modes shows up as a wrong `match_rule` code, even when `accept` happens to be right.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } addr_class_t;

  typedef enum logic [2:0] {
    RULE_NONE    = 3'd0,
    RULE_PERFECT = 3'd1,
    RULE_INVERSE = 3'd2,
    RULE_HASH    = 3'd3,
    RULE_ALLMC   = 3'd4,
    RULE_BCAST   = 3'd5,
    RULE_PROMISC = 3'd6,
    RULE_STATUS  = 3'd7
  } match_rule_t;
endpackage

// File: rtl/rxaf_classify.sv
module rxaf_classify #(
  parameter int AW = 48
) (
  input  logic [AW-1:0] dest,
  input  logic [AW-1:0] station,
  output logic          is_ucast,
  output logic          is_mcast,
  output logic          is_bcast,
  output logic          perfect
);
  logic group_bit;
  logic all_ones;

  assign group_bit = dest[0];
  assign all_ones  = &dest;
  assign is_bcast  = all_ones;
  assign is_mcast  = group_bit & ~all_ones;
  assign is_ucast  = ~group_bit;
  assign perfect   = ~group_bit & (dest == station);
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash #(
  parameter int          AW   = 48,
  parameter int          HW   = 6,
  parameter int          CW   = 32,
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic [AW-1:0] dest,
  output logic [HW-1:0] index
);
  localparam int TOP = CW - HW;

  function automatic logic [CW-1:0] crc_of(input logic [AW-1:0] d);
    logic [CW-1:0] c;
    logic          fb;
    c = '1;
    for (int i = 0; i < AW; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ POLY[CW-1:0];
    end
    return c;
  endfunction

  logic [CW-1:0] crc;
  assign crc   = crc_of(dest);
  assign index = crc[CW-1:TOP];
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        addr_valid,
  input  logic        is_ucast,
  input  logic        is_mcast,
  input  logic        is_bcast,
  input  logic        perfect,
  input  logic        hash_hit,
  input  logic        promisc,
  input  logic        pass_all_mcast,
  input  logic        inverse_match,
  input  logic        bcast_disable,
  input  logic        pass_all_status,
  output logic        accept_q,
  output logic        pass_q,
  output addr_class_t class_q,
  output match_rule_t rule_q
);
  logic        f_pass;
  match_rule_t f_rule;
  match_rule_t final_rule;
  addr_class_t cls;

  always_comb begin
    f_pass = 1'b0;
    f_rule = RULE_NONE;
    cls    = CLS_UCAST;
    if (is_bcast) begin
      cls = CLS_BCAST;
      if (!bcast_disable) begin
        f_pass = 1'b1;
        f_rule = RULE_BCAST;
      end
    end else if (is_mcast) begin
      cls = CLS_MCAST;
      if (hash_hit) begin
        f_pass = 1'b1;
        f_rule = RULE_HASH;
      end else if (pass_all_mcast) begin
        f_pass = 1'b1;
        f_rule = RULE_ALLMC;
      end
    end else if (is_ucast) begin
      if (inverse_match) begin
        if (!perfect) begin
          f_pass = 1'b1;
          f_rule = RULE_INVERSE;
        end
      end else if (perfect) begin
        f_pass = 1'b1;
        f_rule = RULE_PERFECT;
      end
    end

    if (promisc)              final_rule = RULE_PROMISC;
    else if (f_pass)          final_rule = f_rule;
    else if (pass_all_status) final_rule = RULE_STATUS;
    else                      final_rule = RULE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q <= 1'b0;
      pass_q   <= 1'b0;
      class_q  <= CLS_UCAST;
      rule_q   <= RULE_NONE;
    end else if (addr_valid) begin
      accept_q <= (final_rule != RULE_NONE);
      pass_q   <= f_pass;
      class_q  <= cls;
      rule_q   <= final_rule;
    end
  end

  // R2: outputs hold between strobes
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> $stable(accept_q) && $stable(rule_q) && $stable(class_q) && $stable(pass_q));

  // R9: promiscuous overrides every other rule
  assert_promisc_R9: assert property (@(posedge clk) disable iff (rst)
    addr_valid && promisc |=> accept_q && rule_q == RULE_PROMISC);

  // R8: disabled broadcast is rejected unless an override mode is on
  assert_bcast_off_R8: assert property (@(posedge clk) disable iff (rst)
    addr_valid && is_bcast && bcast_disable && !promisc && !pass_all_status |=> !accept_q);

  // R11: a passing filter always means acceptance
  assert_pass_accept_R11: assert property (@(posedge clk) disable iff (rst)
    pass_q |-> accept_q);

  // R11: acceptance tracks a non-zero rule
  assert_rule_accept_R11: assert property (@(posedge clk) disable iff (rst)
    accept_q == (rule_q != RULE_NONE));

  // R3: group bit clear is classed unicast
  assert_ucast_class_R3: assert property (@(posedge clk) disable iff (rst)
    addr_valid && is_ucast |=> class_q == CLS_UCAST);

  // R10: pass-all-with-status accepts everything
  assert_status_all_R10: assert property (@(posedge clk) disable iff (rst)
    addr_valid && pass_all_status |=> accept_q);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int AW    = 48,
  parameter int NBINS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_valid,
  input  logic [AW-1:0]    dest_addr,
  input  logic [AW-1:0]    station_addr,
  input  logic [NBINS-1:0] hash_table,
  input  logic             promisc,
  input  logic             pass_all_mcast,
  input  logic             inverse_match,
  input  logic             bcast_disable,
  input  logic             pass_all_status,
  output logic             accept,
  output logic             filter_pass,
  output logic [1:0]       addr_class,
  output logic [2:0]       match_rule
);
  localparam int HW = $clog2(NBINS);

  logic          is_ucast, is_mcast, is_bcast, perfect;
  logic [HW-1:0] bin;
  logic          hash_hit;
  addr_class_t   class_q;
  match_rule_t   rule_q;

  rxaf_classify #(.AW(AW)) u_cls (
    .dest     (dest_addr),
    .station  (station_addr),
    .is_ucast (is_ucast),
    .is_mcast (is_mcast),
    .is_bcast (is_bcast),
    .perfect  (perfect)
  );

  rxaf_hash #(.AW(AW), .HW(HW)) u_hash (
    .dest  (dest_addr),
    .index (bin)
  );

  assign hash_hit = is_mcast & hash_table[bin];

  rxaf_decide u_dec (
    .clk             (clk),
    .rst             (rst),
    .addr_valid      (addr_valid),
    .is_ucast        (is_ucast),
    .is_mcast        (is_mcast),
    .is_bcast        (is_bcast),
    .perfect         (perfect),
    .hash_hit        (hash_hit),
    .promisc         (promisc),
    .pass_all_mcast  (pass_all_mcast),
    .inverse_match   (inverse_match),
    .bcast_disable   (bcast_disable),
    .pass_all_status (pass_all_status),
    .accept_q        (accept),
    .pass_q          (filter_pass),
    .class_q         (class_q),
    .rule_q          (rule_q)
  );

  assign addr_class = class_q;
  assign match_rule = rule_q;
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_valid = 1'b0;
  logic [47:0] dest_addr = '0;
  logic [47:0] station_addr = 48'h5634_1200_0A02;
  logic [63:0] hash_table = '0;
  logic        promisc = 0, pass_all_mcast = 0, inverse_match = 0;
  logic        bcast_disable = 0, pass_all_status = 0;
  logic        accept, filter_pass;
  logic [1:0]  addr_class;
  logic [2:0]  match_rule;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .dest_addr(dest_addr),
    .station_addr(station_addr), .hash_table(hash_table), .promisc(promisc),
    .pass_all_mcast(pass_all_mcast), .inverse_match(inverse_match),
    .bcast_disable(bcast_disable), .pass_all_status(pass_all_status),
    .accept(accept), .filter_pass(filter_pass), .addr_class(addr_class),
    .match_rule(match_rule)
  );

  function automatic logic [5:0] bin_of(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c[31:26];
  endfunction

  // packed {accept, filter_pass, class[1:0], rule[2:0]}
  function automatic logic [6:0] model(input logic [47:0] d);
    logic [1:0] cl;
    logic       fp = 0;
    logic [2:0] fr = 0, r;
    if (d == '1) begin
      cl = 2; if (!bcast_disable) begin fp = 1; fr = 5; end
    end else if (d[0]) begin
      cl = 1;
      if (hash_table[bin_of(d)]) begin fp = 1; fr = 3; end
      else if (pass_all_mcast)   begin fp = 1; fr = 4; end
    end else begin
      cl = 0;
      if (inverse_match) begin if (d != station_addr) begin fp = 1; fr = 2; end end
      else if (d == station_addr) begin fp = 1; fr = 1; end
    end
    if (promisc) r = 6; else if (fp) r = fr; else if (pass_all_status) r = 7; else r = 0;
    return {r != 0, fp, cl, r};
  endfunction

  task automatic check(input logic [6:0] exp, input string req);
    logic [6:0] act = {accept, filter_pass, addr_class, match_rule};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run(input logic [47:0] d, input string req);
    logic [6:0] exp;
    @(negedge clk);
    dest_addr = d; addr_valid = 1'b1;
    exp = model(d);
    @(negedge clk);
    addr_valid = 1'b0;
    check(exp, req);
  endtask

  task automatic clear_modes();
    promisc = 0; pass_all_mcast = 0; inverse_match = 0;
    bcast_disable = 0; pass_all_status = 0; hash_table = '0;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk); cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] mc, d;
    logic [6:0]  held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(7'd0, "R1");
    rst = 1'b0;
    @(negedge clk);
    check(7'd0, "R1");

    run(station_addr, "R4");
    check({1'b1, 1'b1, 2'd0, 3'd1}, "R4");
    run(station_addr ^ 48'h0100_0000_0000, "R4");
    check(7'd0, "R4");
    run(48'h1122_3344_5501, "R3");
    check({1'b0, 1'b0, 2'd1, 3'd0}, "R3");
    run('1, "R3");
    check({1'b1, 1'b1, 2'd2, 3'd5}, "R8");

    mc = 48'hABCD_EF01_2333;
    hash_table = 64'd1 << bin_of(mc);
    run(mc, "R5");
    check({1'b1, 1'b1, 2'd1, 3'd3}, "R5");
    hash_table = ~(64'd1 << bin_of(mc));
    run(mc, "R5");
    check({1'b0, 1'b0, 2'd1, 3'd0}, "R5");
    pass_all_mcast = 1;
    run(mc, "R6");
    check({1'b1, 1'b1, 2'd1, 3'd4}, "R6");
    clear_modes();

    inverse_match = 1;
    run(station_addr, "R7");
    check(7'd0, "R7");
    run(48'h0000_0000_0002, "R7");
    check({1'b1, 1'b1, 2'd0, 3'd2}, "R7");
    run(mc, "R7");
    check({1'b0, 1'b0, 2'd1, 3'd0}, "R7");
    clear_modes();

    bcast_disable = 1;
    run('1, "R8");
    check({1'b0, 1'b0, 2'd2, 3'd0}, "R8");
    promisc = 1;
    run('1, "R9");
    check({1'b1, 1'b0, 2'd2, 3'd6}, "R9");
    promisc = 0; pass_all_status = 1;
    run(48'h0000_0000_0004, "R10");
    check({1'b1, 1'b0, 2'd0, 3'd7}, "R10");
    run(station_addr, "R10");
    check({1'b1, 1'b1, 2'd0, 3'd1}, "R10");
    clear_modes();

    run(station_addr, "R2");
    held = {accept, filter_pass, addr_class, match_rule};
    @(negedge clk);
    dest_addr = '1; promisc = 1;
    repeat (2) @(negedge clk);
    check(held, "R2");
    clear_modes();

    for (int n = 0; n < 400; n++) begin
      hash_table = {$urandom, $urandom};
      promisc = ($urandom % 8) == 0;
      pass_all_mcast = ($urandom % 4) == 0;
      inverse_match = ($urandom % 4) == 0;
      bcast_disable = ($urandom % 2) == 0;
      pass_all_status = ($urandom % 6) == 0;
      case ($urandom % 4)
        0: d = station_addr;
        1: d = '1;
        default: d = {$urandom, $urandom};
      endcase
      run(d, "R11");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule